// File: doc/BRIEF.md
# Dual-Path Glitch-Free Clock Generator

This block makes one output clock from a bank of eight free-running source clocks. It has two identical paths. Each path picks one source, divides it by an integer ratio, and passes it through a clock gate. A glitch-free switch then chooses one of the two paths for the output. All settings come from a single 32-bit control word that is sampled as a plain input.

To retune a running clock, software programs the path that is not driving the output and lets it settle. It then flips the output-select bit. The switch first turns off the old path on that path's own falling edge. Only after that does it turn on the new path on the new path's falling edge. The output therefore never shows a runt high or low phase.

A ratio change on a path waits for the end of that path's current division cycle. This means a path that is driving the output can also be retuned without a truncated phase.

Top module: `clkgen_top`

## Requirements
- R1: While `rst_ni` is low, `clk_o` is held low and both switch enables are cleared.
- R2: A path's 3-bit select field picks `src_clk_i[code]`. Path 0 uses ctrl bits 11:9 and path 1 uses bits 27:25. Code 0 is the reference source on `src_clk_i[0]`.
- R3: A path's 7-bit divide field value N makes the path period N+1 source periods, and N = 0 passes the selected source through unchanged. Path 0 uses ctrl bits 6:0 and path 1 uses bits 22:16.
- R4: For N of 1 or more, the divided clock is high for floor(N/2)+1 source periods and low for the remaining periods of each cycle.
- R5: Gate bit 8 (path 0) and gate bit 24 (path 1) pass the path clock when 1. When 0, the gate holds the path clock low, and it only closes while that clock is low.
- R6: Ctrl bit 31 chooses the output path (0 = path 0, 1 = path 1). Once the handoff completes, `clk_o` has the period and high time of the chosen path. While neither path is enabled, `clk_o` is low.
- R7: The handoff is break-before-make. The two enables are never high together, and an enable rises only while the other one is low.
- R8: Across a path switch, no high or low phase of `clk_o` is shorter than the shortest phase of the two paths involved.
- R9: A new divide value is loaded only at the terminal count of the current cycle. A ratio change on the active path therefore produces no phase shorter than the shorter phase of the old and new ratios.
- R10: Changing the select, divide or gate settings of the idle path leaves `clk_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk_i | input | 8 | Source clocks; index 0 is the reference |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 32 | Control word for both paths and the output select |
| clk_o | output | 1 | Generated output clock |

## Verification
The hardest situation to reach is a handoff between two paths whose clocks are unrelated, with either path being much slower than the other. A fault in the break-before-make order shows up only as one short phase during the handover, and only in that window.

The stimulus first gives the two paths very different settings. It then flips the select bit while an edge monitor records the shortest high or low phase in the window. Next it retunes the idle path, switches back, and changes the ratio on the active path mid-cycle under the same monitor.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;
    localparam int NUM_SRC     = 8;
    localparam int SEL_W       = $clog2(NUM_SRC);
    localparam int DIV_W       = 7;
    localparam int NUM_PATH    = 2;
    localparam int CTRL_W      = 32;
    // each path owns one half-word of the control word
    localparam int PATH_STRIDE = 16;
    localparam int GATE_OFS    = 8;
    localparam int SEL_OFS     = 9;
    localparam int OUT_SEL_BIT = 31;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             gate;
        logic [DIV_W-1:0] ratio;
    } path_cfg_t;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] ratio;
        logic             out;
    } div_state_t;

    function automatic path_cfg_t decode_path(input logic [CTRL_W-1:0] ctrl, input int p);
        path_cfg_t cfg;
        cfg.ratio = ctrl[p*PATH_STRIDE +: DIV_W];
        cfg.gate  = ctrl[p*PATH_STRIDE + GATE_OFS];
        cfg.sel   = ctrl[p*PATH_STRIDE + SEL_OFS +: SEL_W];
        return cfg;
    endfunction
endpackage

// File: rtl/clkgen_div.sv
`timescale 1ns/1ps
module clkgen_div
    import clkgen_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] ratio_i,
    output logic             clk_o
);
    div_state_t       st_d, st_q;
    logic             term;
    logic [DIV_W-1:0] cnt_q, ratio_q;

    always_comb begin
        term = (st_q.cnt >= st_q.ratio);
        st_d = st_q;
        if (term) begin
            // new ratio is taken only at the end of a full cycle
            st_d.cnt   = '0;
            st_d.ratio = ratio_i;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.out = ({st_d.cnt, 1'b0} <= {1'b0, st_d.ratio});
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_q   = st_q.cnt;
    assign ratio_q = st_q.ratio;
    // ratio zero bypasses the counter entirely
    assign clk_o   = (ratio_q == '0) ? clk_i : st_q.out;
endmodule

// File: rtl/clkgen_gate.sv
`timescale 1ns/1ps
module clkgen_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic clk_o
);
    logic en_lat;

    // transparent only while the clock is low
    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/clkgen_gfswitch.sv
`timescale 1ns/1ps
module clkgen_gfswitch
    import clkgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                rst_ni,
    input  logic [NUM_PATH-1:0] div_clk_i,
    input  logic [NUM_PATH-1:0] gate_clk_i,
    input  logic                sel_i,
    output logic [NUM_PATH-1:0] en_o,
    output logic                clk_o
);
    for (genvar p = 0; p < NUM_PATH; p++) begin : g_side
        logic                   req;
        logic [SYNC_STAGES-1:0] sync_d, sync_q;

        // request only once the opposite side has released
        assign req = (sel_i == 1'(p)) & ~en_o[NUM_PATH-1-p];

        always_comb begin
            sync_d = {sync_q[SYNC_STAGES-2:0], req};
        end

        always_ff @(negedge div_clk_i[p] or negedge rst_ni) begin
            if (!rst_ni) sync_q <= '0;
            else         sync_q <= sync_d;
        end

        assign en_o[p] = sync_q[SYNC_STAGES-1];
    end

    assign clk_o = |(gate_clk_i & en_o);
endmodule

// File: rtl/clkgen_top.sv
`timescale 1ns/1ps
module clkgen_top
    import clkgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic [NUM_SRC-1:0] src_clk_i,
    input  logic               rst_ni,
    input  logic [CTRL_W-1:0]  ctrl_i,
    output logic               clk_o
);
    logic [NUM_PATH-1:0] div_clk, gate_clk, sw_en;

    for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
        path_cfg_t cfg;
        logic      mux_clk;

        assign cfg     = decode_path(ctrl_i, p);
        assign mux_clk = src_clk_i[cfg.sel];

        clkgen_div u_div (
            .clk_i   (mux_clk),
            .rst_ni  (rst_ni),
            .ratio_i (cfg.ratio),
            .clk_o   (div_clk[p])
        );

        clkgen_gate u_gate (
            .clk_i (div_clk[p]),
            .en_i  (cfg.gate),
            .clk_o (gate_clk[p])
        );
    end

    clkgen_gfswitch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
        .rst_ni     (rst_ni),
        .div_clk_i  (div_clk),
        .gate_clk_i (gate_clk),
        .sel_i      (ctrl_i[OUT_SEL_BIT]),
        .en_o       (sw_en),
        .clk_o      (clk_o)
    );
endmodule

// File: rtl/clkgen_checks.sv
`timescale 1ns/1ps
module clkgen_checks (
    input logic       rst_ni,
    input logic [1:0] div_clk,
    input logic [1:0] en,
    input logic       clk_o
);
    always_comb begin
        if (!rst_ni) assert_quiet_in_reset_R1: assert (!clk_o && en == 2'b00);
    end

    always_comb begin
        assert_never_both_R7: assert (!(en[0] && en[1]));
    end

    always_comb begin
        if (en == 2'b00) assert_parked_low_R6: assert (!clk_o);
    end

    assert_p0_waits_R7: assert property (@(negedge div_clk[0]) disable iff (!rst_ni)
        $rose(en[0]) |-> !en[1]);

    assert_p1_waits_R7: assert property (@(negedge div_clk[1]) disable iff (!rst_ni)
        $rose(en[1]) |-> !en[0]);
endmodule

module clkgen_div_checks
    import clkgen_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic [DIV_W-1:0] cnt,
    input logic [DIV_W-1:0] ratio
);
    assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt <= ratio);

    assert_ratio_at_terminal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ratio != $past(ratio)) |-> ($past(cnt) >= $past(ratio)));
endmodule

bind clkgen_top clkgen_checks u_checks (
    .rst_ni  (rst_ni),
    .div_clk (div_clk),
    .en      (sw_en),
    .clk_o   (clk_o)
);

bind clkgen_div clkgen_div_checks u_div_checks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt    (cnt_q),
    .ratio  (ratio_q)
);

// File: tb/clkgen_top_bench.sv
`timescale 1ns/1ps
module clkgen_top_bench;
    localparam int HALF [8] = '{20, 5, 7, 9, 11, 13, 15, 17};
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic [7:0]  src = '0;
    logic        rst_ni = 1'b1;
    logic [31:0] ctrl = '0;
    logic        clk_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // bench copy of the programmed settings
    int s0, n0, s1, n1;
    bit g0, g1, outsel;

    realtime last_edge = 0.0;
    realtime min_seen  = 1.0e9;
    bit      mon_on    = 1'b0;
    int      edge_cnt  = 0;

    always #10 clk = ~clk;

    for (genvar i = 0; i < 8; i++) begin : g_src
        always #(HALF[i]) src[i] = ~src[i];
    end

    clkgen_top u_clkgen_top (
        .src_clk_i (src),
        .rst_ni    (rst_ni),
        .ctrl_i    (ctrl),
        .clk_o     (clk_o)
    );

    // edge monitor: every output phase is measured
    always @(clk_o) begin
        edge_cnt++;
        if (mon_on && ($realtime - last_edge) < min_seen) min_seen = $realtime - last_edge;
        last_edge = $realtime;
    end

    function automatic real per_of(int s, int n);
        return 2.0 * HALF[s] * (n + 1);
    endfunction

    function automatic real high_of(int s, int n);
        return (n == 0) ? 1.0 * HALF[s] : 2.0 * HALF[s] * (n / 2 + 1);
    endfunction

    function automatic real minph_of(int s, int n);
        return (n == 0) ? 1.0 * HALF[s] : 2.0 * HALF[s] * (n - n / 2);
    endfunction

    task automatic apply();
        ctrl = '0;
        ctrl[6:0]   = 7'(n0);
        ctrl[8]     = g0;
        ctrl[11:9]  = 3'(s0);
        ctrl[22:16] = 7'(n1);
        ctrl[24]    = g1;
        ctrl[27:25] = 3'(s1);
        ctrl[31]    = outsel;
    endtask

    task automatic check(bit ok, string req, string what, real act, real exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    task automatic measure(int s, int n, string req);
        realtime t0, th, t1;
        real per, hi;
        per = per_of(s, n);
        hi  = high_of(s, n);
        #1500;
        @(posedge clk_o) t0 = $realtime;
        repeat (3) begin
            @(negedge clk_o) th = $realtime;
            @(posedge clk_o) t1 = $realtime;
            check(((t1 - t0) - per < 0.01) && (per - (t1 - t0) < 0.01), req, "period", t1 - t0, per);
            check(((th - t0) - hi < 0.01) && (hi - (th - t0) < 0.01), req, "high time", th - t0, hi);
            t0 = t1;
        end
    endtask

    task automatic watch_change(real bound, string req);
        min_seen = 1.0e9;
        mon_on   = 1'b1;
        apply();
        #1500;
        mon_on = 1'b0;
        check(min_seen >= bound - 0.01, req, "shortest phase", min_seen, bound);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int e;
        s0 = 1; n0 = 0; g0 = 1; s1 = 5; n1 = 1; g1 = 1; outsel = 0;
        apply();
        #1 rst_ni = 1'b0;
        // R1: output quiet during reset
        repeat (5) begin
            #37;
            check(clk_o === 1'b0, "R1", "clk_o in reset", real'(clk_o), 0.0);
        end
        #13 rst_ni = 1'b1;

        // R2 R3: source 1 passed straight through
        measure(1, 0, "R3");
        // R3 R4: divide by four
        n0 = 3; apply();
        measure(1, 3, "R4");
        // R4: odd ratio, divide by three
        n0 = 2; apply();
        measure(1, 2, "R4");
        // R2: code 0 is the reference source
        s0 = 0; n0 = 0; apply();
        measure(0, 0, "R2");
        n0 = 1; apply();
        measure(0, 1, "R3");

        // R6 R8 R7: hand over to path 1
        outsel = 1;
        watch_change((minph_of(s0, n0) < minph_of(s1, n1)) ? minph_of(s0, n0) : minph_of(s1, n1), "R8");
        measure(s1, n1, "R6");

        // R10: retune idle path 0, output stays on path 1
        s0 = 3; n0 = 2; g0 = 0; apply();
        measure(s1, n1, "R10");
        g0 = 1; apply();
        measure(s1, n1, "R10");

        // R7 R8: hand back to path 0
        outsel = 0;
        watch_change((minph_of(s0, n0) < minph_of(s1, n1)) ? minph_of(s0, n0) : minph_of(s1, n1), "R7");
        measure(s0, n0, "R6");

        // R5: gate off on the active path stops the output low
        g0 = 0; apply();
        #300;
        e = edge_cnt;
        #1000;
        check(edge_cnt == e, "R5", "edges while gated", real'(edge_cnt - e), 0.0);
        check(clk_o === 1'b0, "R5", "level while gated", real'(clk_o), 0.0);
        g0 = 1; apply();
        measure(s0, n0, "R5");

        // R9: ratio change on the active path mid-cycle
        n0 = 3; apply();
        measure(s0, 3, "R9");
        n0 = 5;
        watch_change(minph_of(s0, 3), "R9");
        measure(s0, 5, "R9");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule